// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Scheduler

This block keeps a 4096-row DRAM refreshed by the CAS-before-RAS method. In this method the device's own row counter picks the row, so no row address is needed. After reset it holds every strobe inactive for a power-up pause of `PAUSE_CYC` clocks. It then runs `WARMUP_CYCLES` refresh cycles of its own accord, one after another, and only after that raises `mem_ready`.

In normal operation an interval timer adds one to a pending-refresh count every `INTERVAL_CYC` clocks. The default of 1560 clocks at 100 MHz gives 4096 rows in under 64 ms. The scheduler asks the access controller for the bus with `rfsh_req`. The controller answers with a one-cycle `rfsh_gnt`. The scheduler then drives `ras_n`/`cas_n`/`we_n` itself for one refresh cycle while `rfsh_busy` is high.

When the bus stays busy, the pending count holds the refreshes that are owed, up to `DEBT_MAX`. When that limit is reached, `rfsh_urgent` tells the controller to close any open page at once. Write enable stays high and the address bus stays at zero throughout, so a refresh cycle can never be decoded as a test-mode entry.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is high, and for `PAUSE_CYC` clocks after it is released, `mem_ready`, `rfsh_req`, `rfsh_urgent` and `rfsh_busy` are low and `ras_n`, `cas_n`, `we_n` are high.
- R2: After the pause, exactly `WARMUP_CYCLES` refresh cycles run without any grant. The first CAS fall is seen in the clock after the pause ends. Successive cycles start `T_CSR+T_RAS+T_RP+1` clocks apart.
- R3: `mem_ready` rises `PAUSE_CYC + WARMUP_CYCLES*(T_CSR+T_RAS+T_RP+1)` clocks after reset release and then stays high.
- R4: In every refresh cycle, `cas_n` falls `T_CSR` clocks before `ras_n` falls. Both stay low for `T_RAS` clocks and rise in the same clock. Both then stay high for at least `T_RP` clocks.
- R5: `we_n` is always high and `dram_addr` is always zero.
- R6: Once ready, the pending count grows by one every `INTERVAL_CYC` clocks. The first increase takes effect `INTERVAL_CYC` clocks after `mem_ready` is first seen high.
- R7: `rfsh_req` is high exactly when the block is ready, the pending count is nonzero and no refresh cycle is in progress.
- R8: A grant is taken only in a clock where `rfsh_req` is high, and `cas_n` then falls in the next clock. A grant in any other clock has no effect on the strobes or on `rfsh_busy`.
- R9: Each completed granted refresh lowers the pending count by one. A timer step and a completion in the same clock leave the count unchanged.
- R10: The pending count saturates at `DEBT_MAX`. `rfsh_urgent` is high exactly while the count equals `DEBT_MAX`.
- R11: `rfsh_busy` is high from the clock `cas_n` falls until `T_RP` clocks after `ras_n` rises, for warm-up and granted cycles alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rfsh_gnt | input | 1 | One-cycle bus grant from the access controller |
| mem_ready | output | 1 | Initialisation complete |
| rfsh_req | output | 1 | Refresh wanted; bus is free to grant |
| rfsh_urgent | output | 1 | Pending count at its limit |
| rfsh_busy | output | 1 | Scheduler owns the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low (held high) |
| dram_addr | output | ADDR_W | Address bus, driven to zero |

## Verification
All strobes and flags leave registers. A grant sampled at one edge therefore shows `cas_n` low right after that edge, and `ras_n` follows `T_CSR` clocks later. `ras_n` and `cas_n` rise together `T_RAS` clocks after that, and `rfsh_busy` drops `T_RP` clocks after the rise.

A driver task computes the clock of each expected CAS fall and queues it. This covers the warm-up cycles, whose starts are derived from the pause length and the cycle stride, and every granted cycle. A monitor samples on the falling clock edge and pops one item per CAS fall. From that fall it checks the RAS edges and the busy drop at their computed offsets.

Timer-driven results are checked at exact clocks counted from the first clock `mem_ready` is seen high: the request at one interval, the urgent flag at the interval where the count reaches its limit. The saturation is then confirmed by draining the count with exactly `DEBT_MAX` grants.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_CSR,
        SEQ_RAS,
        SEQ_PRE
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_PAUSE,
        PH_WARM,
        PH_READY
    } init_phase_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_t;

    localparam strobe_t STROBE_REST = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

    function automatic strobe_t strobe_for(seq_state_e st);
        strobe_t s;
        s = STROBE_REST;
        case (st)
            SEQ_CSR: s.cas_n = 1'b0;
            SEQ_RAS: begin
                s.cas_n = 1'b0;
                s.ras_n = 1'b0;
            end
            default: s = STROBE_REST;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/refsch_period.sv
module refsch_period #(
    parameter int PERIOD = 1560
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/refsch_debt.sv
module refsch_debt #(
    parameter int MAX = 8,
    localparam int CW = $clog2(MAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    localparam logic [CW-1:0] TOP = CW'(MAX);

    logic [CW-1:0] count_nx;

    assign empty = (count == '0);
    assign full  = (count == TOP);

    always_comb begin
        count_nx = count;
        case ({inc, dec})
            2'b10: if (!full)  count_nx = count + 1'b1;
            2'b01: if (!empty) count_nx = count - 1'b1;
            default: count_nx = count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count_nx;
    end
endmodule

// File: rtl/refsch_cbr.sv
module refsch_cbr
    import refsch_pkg::*;
#(
    parameter int T_CSR = 1,
    parameter int T_RAS = 6,
    parameter int T_RP  = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output logic       busy,
    output logic       last,
    output seq_state_e state,
    output strobe_t    strobe
);
    localparam int TMAX = (T_CSR > T_RAS) ? ((T_CSR > T_RP) ? T_CSR : T_RP)
                                          : ((T_RAS > T_RP) ? T_RAS : T_RP);
    localparam int CW = (TMAX > 1) ? $clog2(TMAX) : 1;
    localparam logic [CW-1:0] LD_CSR = CW'(T_CSR - 1);
    localparam logic [CW-1:0] LD_RAS = CW'(T_RAS - 1);
    localparam logic [CW-1:0] LD_RP  = CW'(T_RP - 1);

    logic [CW-1:0] hold;

    assign busy   = (state != SEQ_IDLE);
    assign last   = (state == SEQ_PRE) && (hold == '0);
    assign strobe = strobe_for(state);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            hold  <= '0;
        end else begin
            case (state)
                SEQ_IDLE: if (start) begin
                    state <= SEQ_CSR;
                    hold  <= LD_CSR;
                end
                SEQ_CSR: if (hold == '0) begin
                    state <= SEQ_RAS;
                    hold  <= LD_RAS;
                end else begin
                    hold <= hold - 1'b1;
                end
                SEQ_RAS: if (hold == '0) begin
                    state <= SEQ_PRE;
                    hold  <= LD_RP;
                end else begin
                    hold <= hold - 1'b1;
                end
                SEQ_PRE: if (hold == '0) begin
                    state <= SEQ_IDLE;
                end else begin
                    hold <= hold - 1'b1;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import refsch_pkg::*;
#(
    parameter int ADDR_W        = 12,
    parameter int PAUSE_CYC     = 20000,
    parameter int WARMUP_CYCLES = 8,
    parameter int INTERVAL_CYC  = 1560,
    parameter int DEBT_MAX      = 8,
    parameter int T_CSR         = 1,
    parameter int T_RAS         = 6,
    parameter int T_RP          = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rfsh_gnt,
    output logic              mem_ready,
    output logic              rfsh_req,
    output logic              rfsh_urgent,
    output logic              rfsh_busy,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] dram_addr
);
    localparam int CNT_W = $clog2(DEBT_MAX + 1);
    localparam int WC_W  = $clog2(WARMUP_CYCLES + 1);
    localparam logic [WC_W-1:0] WARM_LAST = WC_W'(WARMUP_CYCLES - 1);

    init_phase_e      phase;
    logic [WC_W-1:0]  warm_cnt;
    logic             pause_done;
    logic             iv_tick;
    logic             seq_start;
    logic             seq_busy;
    logic             seq_last;
    seq_state_e       seq_state;
    strobe_t          strobe;
    logic             warm_start;
    logic             grant_take;
    logic             rfsh_done;
    logic [CNT_W-1:0] pend_cnt;
    logic             pend_empty;
    logic             pend_full;

    refsch_period #(.PERIOD(PAUSE_CYC)) u_pause (
        .clk  (clk),
        .rst  (rst),
        .run  (phase == PH_PAUSE),
        .tick (pause_done)
    );

    refsch_period #(.PERIOD(INTERVAL_CYC)) u_interval (
        .clk  (clk),
        .rst  (rst),
        .run  (phase == PH_READY),
        .tick (iv_tick)
    );

    assign warm_start = (phase == PH_WARM) && !seq_busy;
    assign grant_take = rfsh_gnt && rfsh_req;
    assign seq_start  = warm_start || grant_take;
    assign rfsh_done  = seq_last && (phase == PH_READY);

    refsch_cbr #(.T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)) u_cbr (
        .clk    (clk),
        .rst    (rst),
        .start  (seq_start),
        .busy   (seq_busy),
        .last   (seq_last),
        .state  (seq_state),
        .strobe (strobe)
    );

    refsch_debt #(.MAX(DEBT_MAX)) u_debt (
        .clk   (clk),
        .rst   (rst),
        .inc   (iv_tick),
        .dec   (rfsh_done),
        .count (pend_cnt),
        .empty (pend_empty),
        .full  (pend_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_PAUSE;
            warm_cnt <= '0;
        end else begin
            case (phase)
                PH_PAUSE: if (pause_done) phase <= PH_WARM;
                PH_WARM: if (seq_last) begin
                    warm_cnt <= warm_cnt + 1'b1;
                    if (warm_cnt == WARM_LAST) phase <= PH_READY;
                end
                default: phase <= PH_READY;
            endcase
        end
    end

    assign mem_ready   = (phase == PH_READY);
    assign rfsh_req    = mem_ready && !pend_empty && !seq_busy;
    assign rfsh_urgent = mem_ready && pend_full;
    assign rfsh_busy   = seq_busy;
    assign ras_n       = strobe.ras_n;
    assign cas_n       = strobe.cas_n;
    assign we_n        = strobe.we_n;
    assign dram_addr   = '0;
endmodule

// File: rtl/refsch_checker.sv
module refsch_checker #(
    parameter int ADDR_W   = 12,
    parameter int DEBT_MAX = 8,
    parameter int CNT_W    = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              rfsh_gnt,
    input logic              mem_ready,
    input logic              rfsh_req,
    input logic              rfsh_urgent,
    input logic              rfsh_busy,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] dram_addr,
    input logic [CNT_W-1:0]  pend_cnt,
    input logic              iv_tick,
    input logic              rfsh_done
);
    a_r1_quiet_before_ready: assert property (@(posedge clk) disable iff (rst)
        !mem_ready |-> (!rfsh_req && !rfsh_urgent));

    a_r3_ready_sticky: assert property (@(posedge clk) disable iff (rst)
        mem_ready |=> mem_ready);

    a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> ($past(cas_n) == 1'b0));

    a_r4_rise_together: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> $rose(cas_n));

    a_r5_we_addr_idle: assert property (@(posedge clk) disable iff (rst)
        we_n && (dram_addr == '0));

    a_r7_req_only_free: assert property (@(posedge clk) disable iff (rst)
        rfsh_req |-> (mem_ready && !rfsh_busy));

    a_r8_grant_starts: assert property (@(posedge clk) disable iff (rst)
        (rfsh_gnt && rfsh_req) |=> (!cas_n && ras_n && rfsh_busy));

    a_r8_no_spurious_start: assert property (@(posedge clk) disable iff (rst)
        (mem_ready && !rfsh_busy && !(rfsh_gnt && rfsh_req)) |=> !rfsh_busy);

    a_r9_tick_and_done: assert property (@(posedge clk) disable iff (rst)
        (iv_tick && rfsh_done) |=> (pend_cnt == $past(pend_cnt)));

    a_r9_done_lowers: assert property (@(posedge clk) disable iff (rst)
        (rfsh_done && !iv_tick) |=> (pend_cnt == $past(pend_cnt) - 1'b1));

    a_r6_tick_raises: assert property (@(posedge clk) disable iff (rst)
        (iv_tick && !rfsh_done && (pend_cnt != CNT_W'(DEBT_MAX)))
            |=> (pend_cnt == $past(pend_cnt) + 1'b1));

    a_r10_urgent_at_limit: assert property (@(posedge clk) disable iff (rst)
        rfsh_urgent |-> (rfsh_req || rfsh_busy));
endmodule

bind dram_refresh_sched refsch_checker #(
    .ADDR_W   (ADDR_W),
    .DEBT_MAX (DEBT_MAX),
    .CNT_W    (CNT_W)
) u_refsch_checker (
    .clk         (clk),
    .rst         (rst),
    .rfsh_gnt    (rfsh_gnt),
    .mem_ready   (mem_ready),
    .rfsh_req    (rfsh_req),
    .rfsh_urgent (rfsh_urgent),
    .rfsh_busy   (rfsh_busy),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .dram_addr   (dram_addr),
    .pend_cnt    (pend_cnt),
    .iv_tick     (iv_tick),
    .rfsh_done   (rfsh_done)
);

// File: tb/dram_refresh_sched_bench.sv
module dram_refresh_sched_bench;
    localparam int ADDR_W = 12;
    localparam int PAUSE  = 50;
    localparam int WARM   = 8;
    localparam int INTV   = 200;
    localparam int DMAX   = 8;
    localparam int TCSR   = 1;
    localparam int TRAS   = 6;
    localparam int TRP    = 4;
    localparam int STRIDE = TCSR + TRAS + TRP + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rfsh_gnt = 1'b0;
    logic mem_ready, rfsh_req, rfsh_urgent, rfsh_busy, ras_n, cas_n, we_n;
    logic [ADDR_W-1:0] dram_addr;

    always #4 clk = ~clk;

    dram_refresh_sched #(
        .ADDR_W(ADDR_W), .PAUSE_CYC(PAUSE), .WARMUP_CYCLES(WARM),
        .INTERVAL_CYC(INTV), .DEBT_MAX(DMAX),
        .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP)
    ) u_dram_refresh_sched (
        .clk(clk), .rst(rst), .rfsh_gnt(rfsh_gnt),
        .mem_ready(mem_ready), .rfsh_req(rfsh_req), .rfsh_urgent(rfsh_urgent),
        .rfsh_busy(rfsh_busy), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .dram_addr(dram_addr)
    );

    typedef struct {
        int    at;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks   = 0;
    int   failures = 0;
    int   cyc      = 0;
    int   warm_seen = 0;
    bit   finished = 0;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    // Monitor: pops one expected item per CAS fall and times the rest of the cycle
    logic p_ras = 1'b1, p_cas = 1'b1, p_busy = 1'b0;
    int   s_at = 0;
    int   busy_drop_at = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (p_cas && !cas_n) begin
                s_at = cyc;
                if (!mem_ready) warm_seen++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected CAS fall", cyc, -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(cyc == e.at, e.tag, cyc, e.at);
                end
                chk(rfsh_busy == 1'b1, "R11 busy at CAS fall", int'(rfsh_busy), 1);
                chk(we_n && dram_addr == '0, "R5 we/addr at CAS fall", int'(dram_addr), 0);
            end
            if (p_ras && !ras_n) begin
                chk(cyc == s_at + TCSR, "R4 RAS fall offset", cyc, s_at + TCSR);
                chk(we_n == 1'b1, "R5 we high at RAS fall", int'(we_n), 1);
            end
            if (!p_ras && ras_n) begin
                chk(cyc == s_at + TCSR + TRAS, "R4 RAS rise offset", cyc, s_at + TCSR + TRAS);
                chk(cas_n == 1'b1, "R4 CAS rises with RAS", int'(cas_n), 1);
                busy_drop_at = cyc + TRP;
            end
            if (p_busy && !rfsh_busy)
                chk(cyc == busy_drop_at, "R11 busy drop", cyc, busy_drop_at);
            p_ras  = ras_n;
            p_cas  = cas_n;
            p_busy = rfsh_busy;
        end
    end

    task automatic grant_one(input string tag);
        while (!rfsh_req) @(negedge clk);
        exp_q.push_back('{at: cyc + 1, tag: tag});
        rfsh_gnt = 1'b1;
        @(negedge clk);
        rfsh_gnt = 1'b0;
        chk(rfsh_req == 1'b0, "R7 req low while busy", int'(rfsh_req), 0);
        while (rfsh_busy) @(negedge clk);
    endtask

    initial begin
        int rdy;
        repeat (3) @(negedge clk);
        chk(!mem_ready && !rfsh_req && !rfsh_urgent && !rfsh_busy, "R1 reset flags",
            int'({mem_ready, rfsh_req, rfsh_urgent, rfsh_busy}), 0);
        chk(ras_n && cas_n && we_n, "R1 reset strobes", int'({ras_n, cas_n, we_n}), 7);
        for (int k = 0; k < WARM; k++)
            exp_q.push_back('{at: PAUSE + 1 + k * STRIDE, tag: (k == 0) ? "R1 pause length" : "R2 warm-up start"});
        rst = 1'b0;

        while (!mem_ready) @(negedge clk);
        rdy = cyc;
        chk(rdy == PAUSE + WARM * STRIDE, "R3 ready time", rdy, PAUSE + WARM * STRIDE);
        chk(warm_seen == WARM, "R2 warm-up count", warm_seen, WARM);
        chk(exp_q.size() == 0, "R2 all warm-ups seen", exp_q.size(), 0);
        chk(!rfsh_req && !rfsh_urgent, "R7 no request at ready", int'({rfsh_req, rfsh_urgent}), 0);

        // grant while no request: ignored
        repeat (4) @(negedge clk);
        rfsh_gnt = 1'b1;
        @(negedge clk);
        rfsh_gnt = 1'b0;
        repeat (3) @(negedge clk);
        chk(cas_n && !rfsh_busy, "R8 stray grant ignored", int'({cas_n, rfsh_busy}), 2);

        while (!rfsh_req) @(negedge clk);
        chk(cyc == rdy + INTV, "R6 first request", cyc, rdy + INTV);
        grant_one("R8 granted start");
        chk(!rfsh_req, "R9 count back to zero", int'(rfsh_req), 0);
        chk(mem_ready, "R3 ready stays high", int'(mem_ready), 1);

        while (!rfsh_urgent) @(negedge clk);
        chk(cyc == rdy + (DMAX + 1) * INTV, "R10 urgent at limit", cyc, rdy + (DMAX + 1) * INTV);

        while (cyc < rdy + (DMAX + 2) * INTV + 1) @(negedge clk);
        chk(rfsh_urgent, "R10 urgent held at saturation", int'(rfsh_urgent), 1);
        grant_one("R8 drain start");
        chk(!rfsh_urgent && rfsh_req, "R10 urgent clears after one", int'({rfsh_urgent, rfsh_req}), 1);
        for (int i = 1; i < DMAX - 1; i++) grant_one("R9 drain start");
        chk(rfsh_req, "R9 one refresh still owed", int'(rfsh_req), 1);
        grant_one("R9 drain start");
        chk(!rfsh_req, "R10 saturated count drained by limit", int'(rfsh_req), 0);
        chk(exp_q.size() == 0, "R8 all granted cycles seen", exp_q.size(), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule